// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects interrupt requests from eight device lines and signals the processor on one interrupt output. It records each request on its rising edge. It applies a per-line blocking mask and a fixed ordering in which the lowest-numbered line wins. When the processor acknowledges, the block returns an 8-bit vector number. That number is a programmable base plus the index of the chosen line, so device lines can be moved above the processor's reserved exception numbers.

Software talks to the block through one address bit and a write strobe. A command write of 0x11 starts a three-word setup sequence on the data address, in this order:

1. The vector base.
2. The cascade word. A primary takes a bitmask of lines that have secondaries attached; a secondary takes its identity number.
3. A closing word, normally 0x01.

After setup, data writes load the mask. A command write of 0x20 ends service of the most urgent in-service line. The cascade word is held and shown on an output, but no vectors are forwarded between chips.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the vector output is 0x00, the cascade output is 0x00 and the vector base is 8, so acknowledging line 1 returns 9.
- R2: A request is recorded only on a 0-to-1 transition of its input. A line held high after its request was acknowledged does not raise the interrupt output again.
- R3: Mask bit n set to 1 keeps line n from raising the interrupt output. Its request stays recorded and is served once the bit is cleared. A mask of 0xFF blocks every line.
- R4: Among recorded, unmasked lines, the lowest-numbered line is served first.
- R5: On acknowledge while the interrupt output is high, the vector output becomes the vector base plus the chosen line number. It is updated at the clock edge that samples the acknowledge.
- R6: A command write (address bit 0) of 0x11 starts setup. Data writes (address bit 1) then take, in order: the vector base, the cascade word and the closing word. The three low bits of the base are dropped.
- R7: The cascade word written during setup appears on the cascade output, for example 0x04 for a primary or 0x02 for a secondary.
- R8: From the 0x11 command until the closing word, the interrupt output is low. The mask is cleared to 0x00 when setup starts.
- R9: Acknowledge moves the chosen line from recorded to in-service. A command write of 0x20 ends service of the lowest-numbered in-service line.
- R10: A line cannot raise the interrupt output while that line, or a lower-numbered line, is in service. A lower-numbered line may still interrupt.
- R11: An acknowledge while the interrupt output is low changes neither the vector output nor any recorded request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | 0 selects the command address, 1 selects the data address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| req_in | input | 8 | Device request lines |
| ack | input | 1 | Processor acknowledge |
| irq_out | output | 1 | Interrupt to the processor |
| vec_out | output | 8 | Vector number of the last accepted acknowledge |
| cascade_cfg | output | 8 | Stored cascade word |

## Verification
The bench masks one line with 0xFF, then starts setup, to confirm that setup clears the mask. A design that kept the mask would never deliver that line's request. It stacks three nested services to check preemption and end-of-service order. A design comparing with the wrong in-service bit would either drop the middle request or let a less urgent line in early.

It holds a request high across end-of-service, which catches level-sensitive latching, and writes a base with low bits set, which catches an unaligned vector. An acknowledge with no interrupt pending must leave the vector alone. A design that loads it anyway would return a stale or wrong vector.

// File: rtl/vic_pkg.sv
// Package: shared types and constants for the vectored interrupt controller.
// Assumes an 8-bit data path for commands and vectors.
package vic_pkg;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } vic_state_e;

    localparam logic [DATA_W-1:0] CMD_SETUP  = 8'h11;
    localparam logic [DATA_W-1:0] CMD_EOS    = 8'h20;
    localparam logic [DATA_W-1:0] BASE_RESET = 8'h08;
endpackage

// File: rtl/vic_cfg.sv
// Module: setup sequencer and programmable registers.
// Tracks the setup word order, holds the base, cascade word and mask.
// Emits a one-cycle end-of-service pulse for command 0x20.
// Assumes wr_en is a single-cycle strobe per write.
module vic_cfg
    import vic_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output vic_state_e        state,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] cascade,
    output logic [DATA_W-1:0] mask,
    output logic              eos_pulse
);
    localparam logic [DATA_W-1:0] ALIGN = {{(DATA_W-IDX_W){1'b1}}, {IDX_W{1'b0}}};

    logic cmd_wr;
    logic dat_wr;

    assign cmd_wr = wr_en && !reg_sel;
    assign dat_wr = wr_en && reg_sel;

    // Step through the setup words and load registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_READY;
            base    <= BASE_RESET;
            cascade <= '0;
            mask    <= '0;
        end else if (cmd_wr && wr_data == CMD_SETUP) begin
            state <= ST_BASE;
            mask  <= '0;
        end else if (dat_wr) begin
            unique case (state)
                ST_BASE:  begin base <= wr_data & ALIGN; state <= ST_CASC; end
                ST_CASC:  begin cascade <= wr_data; state <= ST_MODE; end
                ST_MODE:  state <= ST_READY;
                default:  mask <= wr_data;
            endcase
        end
    end

    // End-of-service request, honoured only in normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) eos_pulse <= 1'b0;
        else        eos_pulse <= cmd_wr && wr_data == CMD_EOS && state == ST_READY;
    end
endmodule

// File: rtl/vic_pend.sv
// Module: rising-edge request capture.
// A recorded bit clears when the controller accepts that line.
// A new edge in the same cycle wins over the clear.
module vic_pend #(
    parameter int unsigned NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] req_in,
    input  logic [NLINES-1:0] clr,
    output logic [NLINES-1:0] pend
);
    logic [NLINES-1:0] req_q;

    // Remember last request levels and record new rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req_in;
            pend  <= (pend & ~clr) | (req_in & ~req_q);
        end
    end
endmodule

// File: rtl/vic_prio.sv
// Module: lowest-index-first priority encoder.
// Purely combinational; idx is 0 when nothing is set.
module vic_prio #(
    parameter int unsigned NLINES = 8,
    parameter int unsigned IDX_W  = 3
) (
    input  logic [NLINES-1:0] vec,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    // Scan downward so the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
// Module: top of the vectored interrupt controller.
// Merges the recorded and masked lines with the in-service set, drives the interrupt,
// and forms the vector on acknowledge.
// Assumes ack is a one-cycle pulse.
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NLINES-1:0] req_in,
    input  logic              ack,
    output logic              irq_out,
    output logic [DATA_W-1:0] vec_out,
    output logic [DATA_W-1:0] cascade_cfg
);
    localparam int unsigned IDX_W = $clog2(NLINES);

    vic_state_e        state;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] mask;
    logic              eos_pulse;
    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] isr;
    logic [NLINES-1:0] take_set;
    logic [NLINES-1:0] eos_clr;
    logic              cand_any;
    logic [IDX_W-1:0]  cand_idx;
    logic              isr_any;
    logic [IDX_W-1:0]  isr_idx;
    logic              take;

    vic_cfg #(.IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .state(state), .base(base), .cascade(cascade_cfg),
        .mask(mask[DATA_W-1:0]), .eos_pulse(eos_pulse)
    );

    vic_pend #(.NLINES(NLINES)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .clr(take_set), .pend(pend)
    );

    vic_prio #(.NLINES(NLINES), .IDX_W(IDX_W)) u_prio_req (
        .vec(pend & ~mask[NLINES-1:0]), .any(cand_any), .idx(cand_idx)
    );

    vic_prio #(.NLINES(NLINES), .IDX_W(IDX_W)) u_prio_isr (
        .vec(isr), .any(isr_any), .idx(isr_idx)
    );

    // Interrupt only in normal operation, and only if it beats every in-service line.
    assign irq_out  = (state == ST_READY) && cand_any && (!isr_any || cand_idx < isr_idx);
    assign take     = ack && irq_out;
    assign take_set = take ? (NLINES'(1) << cand_idx) : '0;
    assign eos_clr  = (eos_pulse && isr_any) ? (NLINES'(1) << isr_idx) : '0;

    // In-service set: accepted lines join, end-of-service removes the most urgent.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~eos_clr) | take_set;
    end

    // Vector capture at an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_out <= '0;
        else if (take) vec_out <= base | DATA_W'(cand_idx);
    end
endmodule

// File: rtl/vic_chk.sv
// Module: assertion checker bound to vec_irq_ctrl.
module vic_chk
    import vic_pkg::*;
#(
    parameter int unsigned NLINES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input vic_state_e        state,
    input logic              irq_out,
    input logic              ack,
    input logic              eos_pulse,
    input logic [NLINES-1:0] pend,
    input logic [NLINES-1:0] isr,
    input logic [DATA_W-1:0] mask,
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] vec_out
);
    // R8
    setup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READY) |-> !irq_out);
    // R3
    masked_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((pend & ~mask[NLINES-1:0]) != '0));
    // R9
    isr_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !eos_pulse) |=> ($countones(isr) == $countones($past(isr)) + 1));
    // R5
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out) |=> (vec_out[DATA_W-1:3] == $past(base[DATA_W-1:3])));
    // R11
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_out) |=> $stable(vec_out));
    // R6
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base[2:0] == 3'b000);
endmodule

bind vec_irq_ctrl vic_chk #(.NLINES(NLINES)) u_vic_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .irq_out(irq_out), .ack(ack),
    .eos_pulse(eos_pulse), .pend(pend), .isr(isr), .mask(mask), .base(base),
    .vec_out(vec_out)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    localparam time CLK_T = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] req_in = '0;
    logic       ack = 1'b0;
    logic       irq_out;
    logic [7:0] vec_out;
    logic [7:0] cascade_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .req_in(req_in), .ack(ack), .irq_out(irq_out),
        .vec_out(vec_out), .cascade_cfg(cascade_cfg)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_req(input logic [7:0] v);
        req_in = v;
        @(negedge clk);
    endtask

    // Driver: push the expected vector, then pulse acknowledge.
    task automatic do_ack(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Monitor: compare the vector after each acknowledge edge.
    initial begin
        forever begin
            @(posedge clk);
            if (ack) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 actual %0h expected none", vec_out);
                end else begin
                    check(vec_out, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({7'd0, irq_out}, 8'd0, "R1 irq after reset");
        check(vec_out, 8'h00, "R1 vec after reset");
        check(cascade_cfg, 8'h00, "R1 cascade after reset");

        // Default base 8: line 1 gives 9.
        set_req(8'h02);
        check({7'd0, irq_out}, 8'd1, "R2 edge raises irq");
        do_ack(8'd9, "R1 R5 default vector");
        check({7'd0, irq_out}, 8'd0, "R9 line now in service");
        wr(1'b0, 8'h20);
        @(negedge clk);
        check({7'd0, irq_out}, 8'd0, "R2 held level not relatched");
        set_req(8'h00);

        // Mask all, then setup must clear the mask.
        wr(1'b1, 8'hFF);
        set_req(8'h20);
        check({7'd0, irq_out}, 8'd0, "R3 mask FF blocks");
        wr(1'b0, 8'h11);
        set_req(8'h28);
        check({7'd0, irq_out}, 8'd0, "R8 quiet during setup");
        wr(1'b1, 8'h23);
        wr(1'b1, 8'h04);
        check(cascade_cfg, 8'h04, "R7 primary cascade word");
        check({7'd0, irq_out}, 8'd0, "R8 quiet before closing word");
        wr(1'b1, 8'h01);
        check({7'd0, irq_out}, 8'd1, "R8 mask cleared by setup");
        do_ack(8'd35, "R4 R6 line 3 first, base aligned to 32");
        check({7'd0, irq_out}, 8'd0, "R10 line 5 held by line 3");
        wr(1'b0, 8'h20);
        @(negedge clk);
        check({7'd0, irq_out}, 8'd1, "R9 end of service frees line 5");
        do_ack(8'd37, "R5 line 5 vector");
        wr(1'b0, 8'h20);
        set_req(8'h00);

        // Nested service.
        set_req(8'h40);
        do_ack(8'd38, "R5 line 6");
        set_req(8'h44);
        check({7'd0, irq_out}, 8'd1, "R10 higher line preempts");
        do_ack(8'd34, "R10 line 2 vector");
        set_req(8'h54);
        check({7'd0, irq_out}, 8'd0, "R10 line 4 blocked by line 2");
        wr(1'b0, 8'h20);
        @(negedge clk);
        check({7'd0, irq_out}, 8'd1, "R9 most urgent service ended first");
        do_ack(8'd36, "R10 line 4 vector");
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h20);
        set_req(8'h00);

        // Single-bit mask.
        wr(1'b1, 8'h02);
        set_req(8'h82);
        do_ack(8'd39, "R3 masked line 1 skipped");
        wr(1'b1, 8'h00);
        @(negedge clk);
        check({7'd0, irq_out}, 8'd1, "R3 unmask releases line 1");
        do_ack(8'd33, "R3 line 1 served");
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h20);
        set_req(8'h00);

        // Acknowledge with nothing pending.
        do_ack(8'd33, "R11 idle ack keeps vector");
        check({7'd0, irq_out}, 8'd0, "R11 idle ack no interrupt");
        set_req(8'h01);
        do_ack(8'd32, "R11 line 0 after idle ack");
        wr(1'b0, 8'h20);
        set_req(8'h00);

        // Secondary setup with unaligned base.
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h47);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h01);
        check(cascade_cfg, 8'h02, "R7 secondary identity");
        set_req(8'h01);
        do_ack(8'h40, "R6 low base bits dropped");
        @(negedge clk);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule